// File: doc/BRIEF.md
# Nine-Input Column Counter with 4221 Digit Output

This combinational block takes a column of nine bits that all carry the same binary weight and reports how many of them are set, from 0 to 9, as a single four-bit decimal digit in the 4221 weighted code. The count arrives already in that code, so a decimal digit adder built from 4221 operands can take it without any conversion step.

Internally the nine inputs are split into three fixed groups of three neighbouring bits. Each group goes through a full adder. The three group sums then go through a second full adder, and so do the three group carries. The outputs of these two second-level adders are the four digit bits. The block has no clock and no state. It sits inside a wider multi-operand decimal reduction tree, where one copy is placed per bit position of the digit columns.

Top module: `vbc_nine_to_digit`

## Requirements
- R1: The weighted value 4*digit_o[3] + 2*digit_o[2] + 2*digit_o[1] + digit_o[0] equals the number of ones in bits_i for every one of the 512 input vectors.
- R2: digit_o[0] (weight 1) is the parity of all nine input bits.
- R3: digit_o[1] (weight 2) is set when at least two of the three group sums are set. Group g covers bits_i[3g+2:3g], and its sum is the parity of those three bits.
- R4: digit_o[2] (weight 2) is the exclusive-or of the three group carries. A group carry is set when at least two bits of that group are set.
- R5: digit_o[3] (weight 4) is set when at least two of the three group carries are set.
- R6: An all-zero input gives digit 4'b0000. An all-ones input gives 4'b1111, the code for nine. The weighted value never exceeds nine.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bits_i | input | 9 | Column of nine equal-weight bits; bits [2:0], [5:3] and [8:6] form the three groups |
| digit_o | output | 4 | Count of set bits as a 4221 digit; bit 3 has weight 4, bits 2 and 1 have weight 2, bit 0 has weight 1 |

## Verification
Three events can occur for the same input vector: the sum-merging adder producing a carry (digit_o[1]), the carry-merging adder producing a carry (digit_o[3]), and both at once. This happens whenever two or more groups are odd and two or more groups hold at least two ones. A directed table forces these cases separately and together, for example six ones spread as full, full and empty groups, or as two ones in each group. An exhaustive sweep of all 512 vectors then judges each output bit against a group-count model that the bench computes with arithmetic, and also checks the weighted total against the population count.

// File: rtl/vbc_pkg.sv
package vbc_pkg;

  localparam int GROUP_W    = 3;
  localparam int NUM_GROUPS = 3;
  localparam int IN_W       = GROUP_W * NUM_GROUPS;
  localparam int DIGIT_W    = 4;

  typedef logic [DIGIT_W-1:0] digit4221_t;

  typedef struct packed {
    logic [NUM_GROUPS-1:0] carries;
    logic [NUM_GROUPS-1:0] sums;
  } stage1_t;

  // Majority of three bits, used as the carry of a full adder.
  function automatic logic maj3(logic a, logic b, logic c);
    return (a & b) | (b & c) | (c & a);
  endfunction

  // Numeric value of a 4221-coded digit (weights 4,2,2,1).
  function automatic int digit_value(digit4221_t d);
    int acc;
    acc = 0;
    if (d[3]) acc += 4;
    if (d[2]) acc += 2;
    if (d[1]) acc += 2;
    if (d[0]) acc += 1;
    return acc;
  endfunction

endpackage

// File: rtl/vbc_fa.sv
module vbc_fa (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic sum_o,
  output logic carry_o
);
  import vbc_pkg::*;

  assign sum_o   = a_i ^ b_i ^ c_i;
  assign carry_o = maj3(a_i, b_i, c_i);

  always_comb begin
    if (!$isunknown({a_i, b_i, c_i})) begin
      // R1
      fa_value_chk: assert ((int'(sum_o) + 2 * int'(carry_o)) == $countones({a_i, b_i, c_i}))
        else $error("full adder output does not match its input count");
    end
  end

endmodule

// File: rtl/vbc_group_stage.sv
module vbc_group_stage #(
  parameter int GROUP_W    = vbc_pkg::GROUP_W,
  parameter int NUM_GROUPS = vbc_pkg::NUM_GROUPS,
  localparam int IN_W      = GROUP_W * NUM_GROUPS
) (
  input  logic [IN_W-1:0]       bits_i,
  output logic [NUM_GROUPS-1:0] sums_o,
  output logic [NUM_GROUPS-1:0] carries_o
);

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    logic [GROUP_W-1:0] slice;
    assign slice = bits_i[g*GROUP_W +: GROUP_W];

    vbc_fa u_fa (
      .a_i     (slice[0]),
      .b_i     (slice[1]),
      .c_i     (slice[2]),
      .sum_o   (sums_o[g]),
      .carry_o (carries_o[g])
    );

    always_comb begin
      if (!$isunknown(slice)) begin
        // R4
        grp_carry_chk: assert (carries_o[g] == ($countones(slice) >= 2))
          else $error("group carry wrong");
      end
    end
  end

endmodule

// File: rtl/vbc_digit_merge.sv
module vbc_digit_merge
  import vbc_pkg::*;
(
  input  stage1_t    st_i,
  output digit4221_t digit_o
);

  vbc_fa u_sum_fa (
    .a_i     (st_i.sums[0]),
    .b_i     (st_i.sums[1]),
    .c_i     (st_i.sums[2]),
    .sum_o   (digit_o[0]),
    .carry_o (digit_o[1])
  );

  vbc_fa u_carry_fa (
    .a_i     (st_i.carries[0]),
    .b_i     (st_i.carries[1]),
    .c_i     (st_i.carries[2]),
    .sum_o   (digit_o[2]),
    .carry_o (digit_o[3])
  );

  always_comb begin
    if (!$isunknown(st_i)) begin
      // R3
      sum_major_chk: assert (digit_o[1] == ($countones(st_i.sums) >= 2))
        else $error("sum majority bit wrong");
      // R5
      carry_major_chk: assert (digit_o[3] == ($countones(st_i.carries) >= 2))
        else $error("carry majority bit wrong");
    end
  end

endmodule

// File: rtl/vbc_nine_to_digit.sv
module vbc_nine_to_digit
  import vbc_pkg::*;
(
  input  logic [IN_W-1:0]    bits_i,
  output logic [DIGIT_W-1:0] digit_o
);

  stage1_t stage1;

  vbc_group_stage #(
    .GROUP_W    (GROUP_W),
    .NUM_GROUPS (NUM_GROUPS)
  ) u_groups (
    .bits_i    (bits_i),
    .sums_o    (stage1.sums),
    .carries_o (stage1.carries)
  );

  vbc_digit_merge u_merge (
    .st_i    (stage1),
    .digit_o (digit_o)
  );

  always_comb begin
    if (!$isunknown(bits_i)) begin
      // R1
      popcount_chk: assert (digit_value(digit_o) == $countones(bits_i))
        else $error("digit value differs from population count");
      // R2
      parity_chk: assert (digit_o[0] == (^bits_i))
        else $error("weight-one bit is not the input parity");
      // R6
      digit_range_chk: assert (digit_value(digit_o) <= 9)
        else $error("digit out of decimal range");
    end
  end

endmodule

// File: tb/vbc_nine_to_digit_test.sv
module vbc_nine_to_digit_test;

  logic       clk = 1'b0;
  logic [8:0] bits;
  logic [3:0] digit;
  int         n_checks = 0;
  int         n_fail   = 0;
  bit         done     = 1'b0;

  always #10 clk = ~clk;

  vbc_nine_to_digit uut (
    .bits_i  (bits),
    .digit_o (digit)
  );

  // {input, expected digit}
  localparam logic [12:0] VEC [8] = '{
    {9'h000, 4'b0000},  // zero
    {9'h1FF, 4'b1111},  // nine: both merge carries
    {9'h001, 4'b0001},
    {9'h100, 4'b0001},
    {9'h007, 4'b0101},  // one full group
    {9'h049, 4'b0011},  // one per group: sum-merge carry only
    {9'h03F, 4'b1010},  // full,full,empty: both merge carries
    {9'h0DB, 4'b1100}   // two per group: carry-merge carry only
  };

  task automatic check(string req, logic [3:0] act, logic [3:0] exp, logic [8:0] v);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s input=%h actual=%b expected=%b", req, v, act, exp);
    end
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    bits = '0;
    @(negedge clk);
    @(posedge clk);
    #1 check("R6 reset-state zero", digit, 4'b0000, bits);

    for (int i = 0; i < 8; i++) begin
      @(negedge clk) bits = VEC[i][12:4];
      @(posedge clk);
      #1 check("R1/R6 table", digit, VEC[i][3:0], bits);
    end

    for (int v = 0; v < 512; v++) begin
      logic [8:0] vec;
      int cnt, ssum, csum, total;
      logic [3:0] exp;
      vec = 9'(v);
      ssum = 0; csum = 0; total = 0;
      for (int g = 0; g < 3; g++) begin
        cnt = int'(vec[3*g]) + int'(vec[3*g+1]) + int'(vec[3*g+2]);
        ssum += cnt % 2;
        csum += cnt / 2;
        total += cnt;
      end
      exp[0] = (ssum % 2) == 1;
      exp[1] = ssum >= 2;
      exp[2] = (csum % 2) == 1;
      exp[3] = csum >= 2;
      @(negedge clk) bits = vec;
      @(posedge clk);
      #1;
      check("R2 weight-one bit", {3'b000, digit[0]}, {3'b000, exp[0]}, vec);
      check("R3 sum-merge carry", {3'b000, digit[1]}, {3'b000, exp[1]}, vec);
      check("R4 carry xor", {3'b000, digit[2]}, {3'b000, exp[2]}, vec);
      check("R5 carry-merge carry", {3'b000, digit[3]}, {3'b000, exp[3]}, vec);
      check("R1 weighted value",
            4'(4 * int'(digit[3]) + 2 * int'(digit[2]) + 2 * int'(digit[1]) + int'(digit[0])),
            4'(total), vec);
    end

    @(negedge clk) bits = 9'h1FF;
    @(posedge clk);
    #1 check("R6 all ones", digit, 4'b1111, bits);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule